// File: doc/BRIEF.md
# GPIO Change Interrupt With Read Release

This block watches a set of general-purpose input banks (five banks of eight bits by default) and drives an active-low interrupt level toward an open-drain pad. Each bank keeps a snapshot of the value the host last read from it. A bank is pending while its live input differs from that snapshot in any bit whose mask bit is clear. While any bank is pending, the interrupt is asserted.

The register access logic reports every input-bank read with a strobe, a bank index, and a flag that marks the first read of a sequence. A read copies the bank's live pins into its snapshot and clears its pending state. When a sequence starts, the block records the highest-numbered bank that is pending at that moment. The interrupt stays asserted until the host reads that bank, even if lower banks have already been read. The interrupt also stays asserted if the recorded bank's input has since returned to its snapshot value.

The pad cell turns the level into an open-drain output. A 0 on `int_n_o` enables the pull-down, and a 1 releases the line.

Top module: `gpio_chg_irq`

## Requirements
- R1: While `rst_n` is low, each bank's snapshot loads the current pins and all pending and hold state clears. In the first cycle after reset, `int_n_o` is 1.
- R2: Pin bits are packed with bank b in bits [b*8+7 : b*8]. If an unmasked pin bit differs from its snapshot at a rising clock edge, `int_n_o` is 0 after that edge.
- R3: A mask bit of 1 in `mask_i` (same packing as the pins) excludes that pin bit from change detection. A masked change alone never pulls `int_n_o` low. Clearing the mask later exposes any difference that is still present.
- R4: A read is `rd_stb_i`=1 with `rd_bank_i`=b, where b is less than the bank count. A read loads bank b's snapshot from its pins and clears bank b's pending state at that edge.
- R5: If a changed input returns to its snapshot value before the bank is read, that bank stops being pending. With nothing else pending and no hold, `int_n_o` returns to 1.
- R6: A read with `rd_start_i`=1 records the highest-numbered pending bank as the release target. `int_n_o` stays 0 until that bank is read. This holds even when lower-numbered changed banks are read first.
- R7: Once a target is recorded, `int_n_o` stays 0 until the target bank is read, even if the target bank's input has meanwhile returned to its snapshot.
- R8: A new sequence start replaces the recorded target. A sequence start while no bank is pending drops the hold.
- R9: A strobe whose `rd_bank_i` is not below the bank count is ignored entirely. No snapshot, pending flag, target or hold changes, and this includes starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_BANKS*BANK_W | Synchronized pin values, bank b in bits [b*BANK_W +: BANK_W] |
| mask_i | input | NUM_BANKS*BANK_W | Per-bit change mask, 1 = ignore that bit |
| rd_stb_i | input | 1 | An input bank is being read this cycle |
| rd_start_i | input | 1 | This read is the first of a read sequence |
| rd_bank_i | input | $clog2(NUM_BANKS) | Index of the bank being read |
| int_n_o | output | 1 | Interrupt level, 0 = asserted (drives open-drain pull-down) |

## Verification
Some properties are checked on every cycle by assertions. A read always leaves its bank not pending. A fully masked bank never becomes pending. The hold only drops on a read strobe. An out-of-range index leaves the hold and target untouched. The interrupt is released right after reset.

Other behaviour depends on multi-cycle stories and only the bench scenarios can show it. These are the release ordering across banks read from zero upward, the hold that outlives a reverted target input, and target replacement by a new sequence. A behavioural model compares `int_n_o` on every clock during directed and random traffic.

// File: rtl/gpio_chg_pkg.sv
// gpio_chg_pkg
// Shared defaults and helpers for the GPIO change interrupt block.
// Assumes no more than 32 banks, the width the index helper scans.
package gpio_chg_pkg;

    localparam int unsigned GCI_BANKS_DEF = 5;
    localparam int unsigned GCI_WIDTH_DEF = 8;

    // Returns the index of the highest set bit, or 0 when none is set.
    function automatic int unsigned gci_top_index(input logic [31:0] vec);
        int unsigned r;
        r = 0;
        for (int unsigned i = 0; i < 32; i++) begin
            if (vec[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_chg_bank.sv
// gpio_chg_bank
// Tracks one input bank. Keeps the value last read by the host and
// flags the bank pending while an unmasked live bit differs from it.
// Assumes pin_i is already synchronized to clk. The parent decodes rd_hit_i.
module gpio_chg_bank #(
    parameter int unsigned BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] pin_i,
    input  logic [BANK_W-1:0] mask_i,
    input  logic              rd_hit_i,
    output logic              pend_o
);

    logic [BANK_W-1:0] snap_q;
    logic              pend_q;
    logic [BANK_W-1:0] diff_bits;

    // Unmasked bits that moved away from the last-read value
    always_comb begin
        diff_bits = (pin_i ^ snap_q) & ~mask_i;
    end

    // Snapshot capture on reset or read, pending flag otherwise follows the difference
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= pin_i;
            pend_q <= 1'b0;
        end else if (rd_hit_i) begin
            snap_q <= pin_i;
            pend_q <= 1'b0;
        end else begin
            pend_q <= |diff_bits;
        end
    end

    assign pend_o = pend_q;

    // R4
    rd_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit_i |=> !pend_o);

    // R3
    full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_i) |=> !pend_o);

    // R9
    snap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit_i |=> $stable(snap_q));

endmodule

// File: rtl/gpio_chg_release.sv
// gpio_chg_release
// Holds the interrupt until the highest bank that was pending when a
// read sequence started has been read. Out-of-range indices are ignored.
// Assumes NUM_BANKS <= 32 and one read strobe per bank access.
module gpio_chg_release
    import gpio_chg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = GCI_BANKS_DEF,
    parameter int unsigned IDX_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] pend_i,
    input  logic                 rd_stb_i,
    input  logic                 rd_start_i,
    input  logic [IDX_W-1:0]     rd_bank_i,
    output logic                 hold_o
);

    logic             rd_ok;
    logic [IDX_W-1:0] cap_idx;
    logic             any_pend;
    logic             hold_q;
    logic [IDX_W-1:0] tgt_q;

    // Read qualification and target candidate
    always_comb begin
        rd_ok    = rd_stb_i && (int'(rd_bank_i) < int'(NUM_BANKS));
        any_pend = |pend_i;
        cap_idx  = IDX_W'(gci_top_index(32'(pend_i)));
    end

    // Target capture at sequence start, release when the target is read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            tgt_q  <= '0;
        end else if (rd_ok) begin
            if (rd_start_i) begin
                if (any_pend) begin
                    tgt_q  <= cap_idx;
                    hold_q <= (rd_bank_i != cap_idx);
                end else begin
                    hold_q <= 1'b0;
                end
            end else if (hold_q && (rd_bank_i == tgt_q)) begin
                hold_q <= 1'b0;
            end
        end
    end

    assign hold_o = hold_q;

    // R6
    hold_fall_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_q) |-> $past(rd_stb_i));

    // R9
    bad_index_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && (int'(rd_bank_i) >= int'(NUM_BANKS))) |=> ($stable(hold_q) && $stable(tgt_q)));

    // R8
    idle_start_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && rd_start_i && (pend_i == '0)) |=> (!hold_q || $past(int'(rd_bank_i) >= int'(NUM_BANKS))));

endmodule

// File: rtl/gpio_chg_irq.sv
// gpio_chg_irq
// Top of the GPIO change interrupt. One tracker per bank is generated,
// read strobes are decoded per bank, and the release controller holds
// the interrupt until the captured target bank is read.
// Assumes pins are synchronized and the pad makes int_n_o open-drain.
module gpio_chg_irq
    import gpio_chg_pkg::*;
#(
    parameter int unsigned NUM_BANKS = GCI_BANKS_DEF,
    parameter int unsigned BANK_W    = GCI_WIDTH_DEF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0]   pin_i,
    input  logic [NUM_BANKS*BANK_W-1:0]   mask_i,
    input  logic                          rd_stb_i,
    input  logic                          rd_start_i,
    input  logic [$clog2(NUM_BANKS)-1:0]  rd_bank_i,
    output logic                          int_n_o
);

    localparam int unsigned IDX_W = $clog2(NUM_BANKS);

    logic [NUM_BANKS-1:0] pend;
    logic [NUM_BANKS-1:0] rd_hit;
    logic                 hold;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [IDX_W-1:0] BID = IDX_W'(b);

        // Per-bank read decode
        always_comb begin
            rd_hit[b] = rd_stb_i && (rd_bank_i == BID);
        end

        gpio_chg_bank #(
            .BANK_W (BANK_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (pin_i[b*BANK_W +: BANK_W]),
            .mask_i   (mask_i[b*BANK_W +: BANK_W]),
            .rd_hit_i (rd_hit[b]),
            .pend_o   (pend[b])
        );
    end

    gpio_chg_release #(
        .NUM_BANKS (NUM_BANKS),
        .IDX_W     (IDX_W)
    ) u_release (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend),
        .rd_stb_i   (rd_stb_i),
        .rd_start_i (rd_start_i),
        .rd_bank_i  (rd_bank_i),
        .hold_o     (hold)
    );

    // Interrupt level: low while anything is pending or held
    always_comb begin
        int_n_o = ~((|pend) | hold);
    end

    // R1
    int_idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> int_n_o);

    // R6
    held_means_asserted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !rd_stb_i) |=> !int_n_o);

endmodule

// File: tb/gpio_chg_irq_tb.sv
module gpio_chg_irq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 5;
    localparam int W  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NB*W-1:0] pins_r = 40'h1122334455;
    logic [NB*W-1:0] mask_r = '0;
    logic            rd_stb = 1'b0;
    logic            rd_start = 1'b0;
    logic [2:0]      rd_bank = '0;
    logic            int_n_o;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // Behavioural reference state
    logic [W-1:0]  m_snap [NB];
    logic [NB-1:0] m_pend = '0;
    logic [NB-1:0] m_np;
    bit            m_hold = 1'b0;
    int            m_tgt = 0;
    int            m_hi;
    bit            m_rdok;
    bit            m_exp;

    gpio_chg_irq #(.NUM_BANKS(NB), .BANK_W(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pins_r),
        .mask_i     (mask_r),
        .rd_stb_i   (rd_stb),
        .rd_start_i (rd_start),
        .rd_bank_i  (rd_bank),
        .int_n_o    (int_n_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model, one update per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) m_snap[b] = pins_r[b*W +: W];
            m_pend = '0;
            m_hold = 0;
            m_tgt  = 0;
        end else begin
            m_hi = -1;
            for (int b = 0; b < NB; b++) if (m_pend[b]) m_hi = b;
            m_rdok = rd_stb && (int'(rd_bank) < NB);
            if (m_rdok) begin
                if (rd_start) begin
                    if (m_hi >= 0) begin
                        m_tgt  = m_hi;
                        m_hold = (int'(rd_bank) != m_hi);
                    end else begin
                        m_hold = 0;
                    end
                end else if (m_hold && int'(rd_bank) == m_tgt) begin
                    m_hold = 0;
                end
            end
            for (int b = 0; b < NB; b++) begin
                if (m_rdok && int'(rd_bank) == b) begin
                    m_np[b]   = 1'b0;
                    m_snap[b] = pins_r[b*W +: W];
                end else begin
                    m_np[b] = (((pins_r[b*W +: W] ^ m_snap[b]) & ~mask_r[b*W +: W]) != '0);
                end
            end
            m_pend = m_np;
        end
        m_exp = !((m_pend != '0) || m_hold);
    end

    // Model comparison on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (int_n_o !== m_exp) begin
                failures++;
                $display("FAIL %s model compare t=%0t: int_n_o=%0b expected=%0b", cur_tag, $time, int_n_o, m_exp);
            end
        end
    end

    task automatic expect_int(input bit exp, input string tag);
        checks++;
        if (int_n_o !== exp) begin
            failures++;
            $display("FAIL %s directed: int_n_o=%0b expected=%0b", tag, int_n_o, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_read(input int bank, input bit start);
        rd_stb   = 1'b1;
        rd_bank  = 3'(bank);
        rd_start = start;
        tick();
        rd_stb   = 1'b0;
        rd_start = 1'b0;
    endtask

    task automatic flip(input int bank, input logic [7:0] bits);
        pins_r[bank*W +: W] = pins_r[bank*W +: W] ^ bits;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: released after reset with snapshot equal to non-zero pins
        cur_tag = "R1";
        expect_int(1'b1, "R1");

        // R2: unmasked change in bank 0
        cur_tag = "R2";
        flip(0, 8'h08);
        tick();
        expect_int(1'b0, "R2");
        // R4: reading bank 0 clears it
        cur_tag = "R4";
        do_read(0, 1'b1);
        expect_int(1'b1, "R4");

        // R3: masked change stays quiet, unmask exposes it
        cur_tag = "R3";
        mask_r[1*W +: W] = 8'hFF;
        flip(1, 8'hF0);
        tick();
        expect_int(1'b1, "R3");
        tick();
        expect_int(1'b1, "R3");
        mask_r = '0;
        tick();
        expect_int(1'b0, "R3");
        do_read(1, 1'b1);
        expect_int(1'b1, "R4");

        // R6: banks 2 and 4 change together, read upward from bank 0
        cur_tag = "R6";
        flip(2, 8'h01);
        flip(4, 8'h80);
        tick();
        expect_int(1'b0, "R2");
        do_read(0, 1'b1);
        expect_int(1'b0, "R6");
        do_read(1, 1'b0);
        do_read(2, 1'b0);
        expect_int(1'b0, "R6");
        do_read(3, 1'b0);
        expect_int(1'b0, "R6");
        do_read(4, 1'b0);
        expect_int(1'b1, "R6");

        // R7: target input reverts, hold persists until it is read
        cur_tag = "R7";
        flip(3, 8'h02);
        flip(4, 8'h04);
        tick();
        do_read(0, 1'b1);
        flip(4, 8'h04);
        tick();
        expect_int(1'b0, "R7");
        do_read(1, 1'b0);
        do_read(2, 1'b0);
        do_read(3, 1'b0);
        expect_int(1'b0, "R7");
        do_read(4, 1'b0);
        expect_int(1'b1, "R7");

        // R5: change then revert before any read
        cur_tag = "R5";
        flip(1, 8'h10);
        tick();
        expect_int(1'b0, "R5");
        flip(1, 8'h10);
        tick();
        expect_int(1'b1, "R5");

        // R8: start with nothing pending drops the hold
        cur_tag = "R8";
        flip(4, 8'h40);
        tick();
        do_read(0, 1'b1);
        flip(4, 8'h40);
        tick();
        expect_int(1'b0, "R8");
        do_read(0, 1'b1);
        expect_int(1'b1, "R8");

        // R9: out-of-range strobes change nothing
        cur_tag = "R9";
        flip(0, 8'h02);
        tick();
        expect_int(1'b0, "R9");
        do_read(5, 1'b1);
        expect_int(1'b0, "R9");
        do_read(7, 1'b0);
        expect_int(1'b0, "R9");
        flip(0, 8'h02);
        tick();
        expect_int(1'b1, "R9");

        // Random traffic against the model (R2 R3 R5 R6 R7 R8 R9)
        cur_tag = "random R6";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 5) == 0)
                pins_r = pins_r ^ (40'(1) << $urandom_range(0, NB*W-1));
            if ($urandom_range(0, 60) == 0)
                mask_r = {$urandom(), $urandom()} & {$urandom(), $urandom()};
            if ($urandom_range(0, 3) == 0) begin
                rd_stb   = 1'b1;
                rd_bank  = 3'($urandom_range(0, 7));
                rd_start = ($urandom_range(0, 3) == 0);
            end else begin
                rd_stb   = 1'b0;
                rd_start = 1'b0;
            end
            tick();
        end
        rd_stb = 1'b0;
        tick();
        finish_run();
    end

endmodule